// File: doc/BRIEF.md
# Transmit Cell Statistics Counter Bank

This block keeps the statistics of a cell transmit path. It has three event counters. The transmitted-cell counter counts cells taken from the transmit queue. The filler counter counts idle or unassigned cells inserted into the stream. The corrupt-cell counter counts damaged cells and has a programmable threshold. Each counter advances by one in every clock cycle in which its event input is high and its enable bit is set. When a counter reaches all ones it stops there and does not wrap.

Software reaches the block through a byte-wide register port. Each counter owns two adjacent addresses, and both return its least significant byte. The higher address is a plain read. The lower address is a read-and-clear, which returns the value from before the clear and then empties the counter. Any low-byte read also copies the counter's middle and top bytes into two shared snapshot registers. A value wider than a byte therefore reads out coherently, even while the counter keeps moving.

A sticky interrupt register records two kinds of event: the corrupt-cell counter crossing its threshold, and any counter saturating. Each bit is cleared by writing 1 to it. A per-bit mask feeds a main interrupt register, and a second mask gates the single interrupt output.

Top module: `cell_stat_bank`

## Requirements
- R1: After reset, all of the following are zero: every counter, the enable register at 0x02 (all three bits), both snapshot registers, the interrupt, mask and main registers, `reg_rdata` and `irq`. The threshold register at 0x0A resets to 2^(ERR_W-1), which is 0x80 at the default width.
- R2: Enable bits at 0x02 are assigned as follows: bit 0 for the transmitted-cell counter, bit 1 for the filler counter, bit 2 for the corrupt-cell counter. A counter rises by one in each cycle in which its event input is high and its enable bit is 1. When the enable bit is 0 the counter holds its value.
- R3: A counter that holds all ones stays at all ones on further events.
- R4: The low-byte base addresses are 0x05 for transmitted cells, 0x07 for filler cells and 0x09 for corrupt cells. Reading a base address, or the address one below it, returns the counter's bits 7:0. Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. A read at the base address leaves the counter unchanged.
- R5: A read at base-1 (0x04, 0x06, 0x08) returns the value from before the clear. The counter is zero afterwards.
- R6: If an enabled event arrives in the same cycle as a clearing read of its counter, the counter becomes 1.
- R7: Every low-byte read copies counter bits 15:8 into the snapshot register at 0x00 and bits 23:16 into the snapshot register at 0x01. Counters narrower than 24 bits are zero-extended. Both snapshot registers keep their values until the next low-byte read.
- R8: Interrupt bit 0 at 0x3A is set in the cycle after the corrupt-cell count is greater than or equal to the ERR_W-bit threshold at 0x0A. The bit stays set until software writes 1 to it. If the set condition and the write-1 clear fall in the same cycle, the set wins.
- R9: Interrupt bits 1, 2 and 3 at 0x3A are set in the cycle after the transmitted-cell, filler or corrupt-cell counter, respectively, holds all ones. Like bit 0, they are sticky and are cleared by writing 1.
- R10: Bit 0 of the main register at 0x38 is the OR of those interrupt bits whose mask bit at 0x3B is 0. Bit 1 of the main register reads 0. `irq` equals main bit 0 whenever main mask bit 0 at 0x39 is 0, and is 0 otherwise.
- R11: Writes to counter or snapshot addresses have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_tx | input | 1 | One transmitted cell this cycle |
| evt_idle | input | 1 | One idle/unassigned cell inserted this cycle |
| evt_err | input | 1 | One corrupted cell this cycle |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W=12 and ERR_W=5. At these widths the event counters saturate after 4095 events and the corrupt-cell counter after 31. This brings the stop-at-all-ones behaviour and the saturation interrupt bits within reach of a short run. The 12-bit width still carries a nonzero middle byte into the snapshot register, and the top snapshot byte exercises the zero-extension path. The threshold default of 16 lies inside the error counter's range, so random corrupt-cell traffic crosses it repeatedly, and the threshold interrupt gets cleared while its condition still holds.

// File: rtl/cell_stat_pkg.sv
// Package: shared constants and address helpers for the cell statistics bank.
// Assumes an 8-bit register address space; counter views are 24 bits wide.
package cell_stat_pkg;

    localparam int VIEW_W   = 24;   // widest counter view seen by the register port
    localparam int NUM_CNT  = 3;    // number of event counters
    localparam int NUM_CIRQ = 4;    // bits in the counter interrupt register

    localparam logic [7:0] A_SNAP_MID = 8'h00;
    localparam logic [7:0] A_SNAP_TOP = 8'h01;
    localparam logic [7:0] A_CNT_EN   = 8'h02;
    localparam logic [7:0] A_ERR_THR  = 8'h0A;
    localparam logic [7:0] A_MAIN     = 8'h38;
    localparam logic [7:0] A_MAIN_MSK = 8'h39;
    localparam logic [7:0] A_CIRQ     = 8'h3A;
    localparam logic [7:0] A_CIRQ_MSK = 8'h3B;

    typedef enum int {CI_TX = 0, CI_IDLE = 1, CI_ERR = 2} cnt_idx_e;

    // Plain-read low-byte address of counter idx; the clearing read sits one below.
    function automatic logic [7:0] cnt_base(input int idx);
        return 8'(5 + 2 * idx);
    endfunction

endpackage

// File: rtl/evt_counter.sv
// Module: evt_counter
// Saturating event counter with a clearing load. Counts one per cycle while
// en and evt are both high; a clear loads 1 if an event arrives with it, else 0.
// Assumes clr is a single-cycle strobe from the register decoder.
module evt_counter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             evt,
    input  logic             clr,
    output logic [WIDTH-1:0] count,
    output logic             at_max
);

    localparam logic [WIDTH-1:0] MAX_VAL = '1;
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    logic bump;

    assign bump   = en & evt;
    assign at_max = (count == MAX_VAL);

    // Count register: reset, clearing load, or saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= bump ? ONE : '0;
        end else if (bump && !at_max) begin
            count <= count + ONE;
        end
    end

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> at_max);

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (count == '0));

    a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt && en) |=> (count == ONE));

    a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count));

endmodule

// File: rtl/stat_irq.sv
// Module: stat_irq
// Sticky counter interrupt register with write-1-to-clear, its mask, the main
// interrupt summary and its mask. A set in the same cycle as a clear wins.
// Assumes write strobes are already decoded to this block's addresses.
module stat_irq
    import cell_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CIRQ-1:0] set_src,
    input  logic                w1c_wr,
    input  logic                cmsk_wr,
    input  logic                mmsk_wr,
    input  logic [NUM_CIRQ-1:0] wdata,
    output logic [NUM_CIRQ-1:0] cirq,
    output logic [NUM_CIRQ-1:0] cirq_msk,
    output logic [1:0]          main_irq,
    output logic [1:0]          main_msk,
    output logic                irq
);

    logic [NUM_CIRQ-1:0] clr_bits;
    logic                any_src;

    assign clr_bits = w1c_wr ? wdata : '0;
    assign any_src  = |(cirq & ~cirq_msk);
    assign main_irq = {1'b0, any_src};
    assign irq      = main_irq[0] & ~main_msk[0];

    // Sticky interrupt bits: clear by write-1, set sources override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cirq <= '0;
        end else begin
            cirq <= (cirq & ~clr_bits) | set_src;
        end
    end

    // Mask registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cirq_msk <= '0;
            main_msk <= '0;
        end else begin
            if (cmsk_wr) cirq_msk <= wdata;
            if (mmsk_wr) main_msk <= wdata[1:0];
        end
    end

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cirq[0] && !(w1c_wr && wdata[0])) |=> cirq[0]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_src[0] |=> cirq[0]);

    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cirq != '0));

endmodule

// File: rtl/stat_regfile.sv
// Module: stat_regfile
// Register-port decoder: enable and threshold registers, counter clear strobes,
// snapshot capture of the upper counter bytes and the registered read mux.
// Assumes reg_rd and reg_wr are single-cycle strobes and one address per cycle.
module stat_regfile
    import cell_stat_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [7:0]                       reg_addr,
    input  logic                             reg_rd,
    input  logic                             reg_wr,
    input  logic [7:0]                       reg_wdata,
    input  logic [NUM_CNT-1:0][VIEW_W-1:0]   cnt_view,
    input  logic [NUM_CIRQ-1:0]              cirq,
    input  logic [NUM_CIRQ-1:0]              cirq_msk,
    input  logic [1:0]                       main_irq,
    input  logic [1:0]                       main_msk,
    output logic [7:0]                       reg_rdata,
    output logic [NUM_CNT-1:0]               cnt_clr,
    output logic [NUM_CNT-1:0]               cnt_en,
    output logic [ERR_W-1:0]                 err_thr,
    output logic                             w1c_wr,
    output logic                             cmsk_wr,
    output logic                             mmsk_wr
);

    localparam logic [ERR_W-1:0] THR_RST = ERR_W'(1) << (ERR_W - 1);

    logic [NUM_CNT-1:0] low_hit;
    logic [NUM_CNT-1:0] addr_low;
    logic               low_any;
    logic [VIEW_W-1:0]  snap_src;
    logic [7:0]         snap_mid;
    logic [7:0]         snap_top;
    logic [7:0]         rd_val;

    // Per-counter address match for the plain and clearing low-byte reads.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_dec
        assign addr_low[gi] = (reg_addr == cnt_base(gi)) ||
                              (reg_addr == cnt_base(gi) - 8'd1);
        assign low_hit[gi]  = reg_rd && addr_low[gi];
        assign cnt_clr[gi]  = reg_rd && (reg_addr == cnt_base(gi) - 8'd1);
    end

    assign w1c_wr  = reg_wr && (reg_addr == A_CIRQ);
    assign cmsk_wr = reg_wr && (reg_addr == A_CIRQ_MSK);
    assign mmsk_wr = reg_wr && (reg_addr == A_MAIN_MSK);

    // Pick the counter whose low byte is being read for the snapshot.
    always_comb begin
        low_any  = 1'b0;
        snap_src = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (low_hit[i]) begin
                low_any  = 1'b1;
                snap_src = cnt_view[i];
            end
        end
    end

    // Snapshot registers capture upper bytes on every low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_mid <= '0;
            snap_top <= '0;
        end else if (low_any) begin
            snap_mid <= snap_src[15:8];
            snap_top <= snap_src[23:16];
        end
    end

    // Configuration registers: count enables and error threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en  <= '0;
            err_thr <= THR_RST;
        end else if (reg_wr) begin
            if (reg_addr == A_CNT_EN)  cnt_en  <= reg_wdata[NUM_CNT-1:0];
            if (reg_addr == A_ERR_THR) err_thr <= reg_wdata[ERR_W-1:0];
        end
    end

    // Read multiplexer over current register contents.
    always_comb begin
        rd_val = '0;
        case (reg_addr)
            A_SNAP_MID: rd_val = snap_mid;
            A_SNAP_TOP: rd_val = snap_top;
            A_CNT_EN:   rd_val = 8'(cnt_en);
            A_ERR_THR:  rd_val = 8'(err_thr);
            A_MAIN:     rd_val = 8'(main_irq);
            A_MAIN_MSK: rd_val = 8'(main_msk);
            A_CIRQ:     rd_val = 8'(cirq);
            A_CIRQ_MSK: rd_val = 8'(cirq_msk);
            default:    rd_val = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr_low[i]) rd_val = cnt_view[i][7:0];
        end
    end

    // Read data register, updated only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_val;
        end
    end

    a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !low_any |=> ($stable(snap_mid) && $stable(snap_top)));

    a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: rtl/cell_stat_bank.sv
// Module: cell_stat_bank (top)
// Statistics bank for a cell transmit path: transmitted, filler and corrupt
// cell counters, snapshot register read-out, threshold and saturation interrupts.
// Assumes CNT_W in 1..24 and ERR_W in 1..8; events are one-cycle pulses.
module cell_stat_bank
    import cell_stat_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int ERR_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_tx,
    input  logic       evt_idle,
    input  logic       evt_err,
    input  logic [7:0] reg_addr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    logic [NUM_CNT-1:0]             evt_vec;
    logic [NUM_CNT-1:0]             cnt_clr;
    logic [NUM_CNT-1:0]             cnt_en;
    logic [NUM_CNT-1:0]             cnt_max;
    logic [NUM_CNT-1:0][VIEW_W-1:0] cnt_view;
    logic [ERR_W-1:0]               err_thr;
    logic [ERR_W-1:0]               err_cnt;
    logic                           thr_hit;
    logic [NUM_CIRQ-1:0]            set_src;
    logic [NUM_CIRQ-1:0]            cirq;
    logic [NUM_CIRQ-1:0]            cirq_msk;
    logic [1:0]                     main_irq;
    logic [1:0]                     main_msk;
    logic                           w1c_wr;
    logic                           cmsk_wr;
    logic                           mmsk_wr;

    assign evt_vec = {evt_err, evt_idle, evt_tx};

    // One counter per event source; the corrupt-cell counter takes ERR_W.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        localparam int W = (gi == CI_ERR) ? ERR_W : CNT_W;
        logic [W-1:0] value;
        evt_counter #(.WIDTH(W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (cnt_en[gi]),
            .evt    (evt_vec[gi]),
            .clr    (cnt_clr[gi]),
            .count  (value),
            .at_max (cnt_max[gi])
        );
        assign cnt_view[gi] = VIEW_W'(value);
    end

    assign err_cnt = cnt_view[CI_ERR][ERR_W-1:0];
    assign thr_hit = (err_cnt >= err_thr);
    assign set_src = {cnt_max, thr_hit};

    stat_regfile #(.ERR_W(ERR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cnt_view  (cnt_view),
        .cirq      (cirq),
        .cirq_msk  (cirq_msk),
        .main_irq  (main_irq),
        .main_msk  (main_msk),
        .reg_rdata (reg_rdata),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .err_thr   (err_thr),
        .w1c_wr    (w1c_wr),
        .cmsk_wr   (cmsk_wr),
        .mmsk_wr   (mmsk_wr)
    );

    stat_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_src  (set_src),
        .w1c_wr   (w1c_wr),
        .cmsk_wr  (cmsk_wr),
        .mmsk_wr  (mmsk_wr),
        .wdata    (reg_wdata[NUM_CIRQ-1:0]),
        .cirq     (cirq),
        .cirq_msk (cirq_msk),
        .main_irq (main_irq),
        .main_msk (main_msk),
        .irq      (irq)
    );

    a_r9_sat_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_max[CI_TX] |=> cirq[1]);

    a_r11_wr_counter_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && !evt_tx && reg_addr == cnt_base(CI_TX))
            |=> $stable(cnt_view[CI_TX]));

endmodule

// File: tb/cell_stat_bank_tb_top.sv
// Bench for cell_stat_bank: directed corner cases plus seeded random traffic,
// checked against a reference model built from the requirements.
module cell_stat_bank_tb_top;

    localparam int CW = 12;
    localparam int EW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_tx = 1'b0, evt_idle = 1'b0, evt_err = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Reference model state
    logic [23:0] m_cnt [3];
    logic [2:0]  m_en;
    logic [7:0]  m_thr, m_mid, m_top, m_rdata;
    logic [3:0]  m_cirq, m_cmask;
    logic [1:0]  m_mmask;

    cell_stat_bank #(.CNT_W(CW), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_tx(evt_tx), .evt_idle(evt_idle),
        .evt_err(evt_err), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5ns clk = ~clk;

    function automatic logic [23:0] cmax(input int k);
        return (k == 2) ? 24'((1 << EW) - 1) : 24'((1 << CW) - 1);
    endfunction

    function automatic logic [7:0] base(input int k);
        return 8'(5 + 2 * k);
    endfunction

    function automatic logic csum();
        return |(m_cirq & ~m_cmask);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        for (int k = 0; k < 3; k++)
            if (a == base(k) || a == base(k) - 8'd1) return m_cnt[k][7:0];
        case (a)
            8'h00:   return m_mid;
            8'h01:   return m_top;
            8'h02:   return {5'b0, m_en};
            8'h0A:   return m_thr;
            8'h38:   return {7'b0, csum()};
            8'h39:   return {6'b0, m_mmask};
            8'h3A:   return {4'b0, m_cirq};
            8'h3B:   return {4'b0, m_cmask};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h01:        return "R7";
            8'h04, 8'h06, 8'h08: return "R5";
            8'h05, 8'h07, 8'h09: return "R4";
            8'h02:               return "R2";
            8'h0A, 8'h3A:        return "R8";
            8'h38, 8'h39, 8'h3B: return "R10";
            default:             return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_init();
        for (int k = 0; k < 3; k++) m_cnt[k] = '0;
        m_en = '0; m_thr = 8'(1 << (EW - 1)); m_mid = '0; m_top = '0;
        m_rdata = '0; m_cirq = '0; m_cmask = '0; m_mmask = '0;
    endtask

    // Reference update for one clock edge, using pre-edge state.
    task automatic model_step(input logic [2:0] ev, input bit rd, input bit wr,
                              input logic [7:0] a, input logic [7:0] d);
        logic [3:0] s;
        logic [7:0] rv;
        rv   = exp_read(a);
        s[0] = (m_cnt[2][7:0] >= m_thr);
        s[1] = (m_cnt[0] == cmax(0));
        s[2] = (m_cnt[1] == cmax(1));
        s[3] = (m_cnt[2] == cmax(2));
        if (rd) begin
            m_rdata = rv;
            for (int k = 0; k < 3; k++)
                if (a == base(k) || a == base(k) - 8'd1) begin
                    m_mid = m_cnt[k][15:8];
                    m_top = m_cnt[k][23:16];
                end
        end
        for (int k = 0; k < 3; k++) begin
            bit inc;
            inc = m_en[k] & ev[k];
            if (rd && a == base(k) - 8'd1) m_cnt[k] = inc ? 24'd1 : 24'd0;
            else if (inc && m_cnt[k] != cmax(k)) m_cnt[k] = m_cnt[k] + 24'd1;
        end
        if (wr) begin
            case (a)
                8'h02: m_en    = d[2:0];
                8'h0A: m_thr   = d & cmax(2)[7:0];
                8'h3A: m_cirq  = m_cirq & ~d[3:0];
                8'h3B: m_cmask = d[3:0];
                8'h39: m_mmask = d[1:0];
                default: ;
            endcase
        end
        m_cirq = m_cirq | s;
    endtask

    // One bus/event cycle: drive at negedge, model at posedge, check at negedge.
    task automatic cyc(input logic [2:0] ev, input bit rd, input bit wr,
                       input logic [7:0] a, input logic [7:0] d, input string req);
        {evt_err, evt_idle, evt_tx} = ev;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_step(ev, rd, wr, a, d);
        @(negedge clk);
        {evt_err, evt_idle, evt_tx} = '0;
        reg_rd = 0; reg_wr = 0;
        if (rd) chk(req, reg_rdata, m_rdata);
        chk("R10", irq, csum() & ~m_mmask[0]);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc(3'b000, 1, 0, a, 8'h00, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        cyc(3'b000, 0, 1, a, d, req);
    endtask

    task automatic events(input logic [2:0] ev, input int n);
        for (int i = 0; i < n; i++) cyc(ev, 0, 0, 8'h00, 8'h00, "R2");
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #1500us;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [15];
        addrs = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                  8'h09, 8'h0A, 8'h38, 8'h39, 8'h3A, 8'h3B, 8'h20};
        void'($urandom(32'h5EED_0C11));
        model_init();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", reg_rdata, 8'h00);
        chk("R1", irq, 1'b0);
        for (int i = 0; i < 15; i++) rd(addrs[i], "R1");
        chk("R1", m_thr, 8'd16);

        // R2: only the transmitted-cell counter enabled
        wr(8'h02, 8'h01, "R2");
        events(3'b111, 5);
        rd(8'h05, "R2"); rd(8'h07, "R2"); rd(8'h09, "R2");
        // R4 plain read keeps value; R5 clearing read returns old value then zero
        rd(8'h05, "R4");
        rd(8'h04, "R5");
        rd(8'h05, "R5");
        // R6: event coincident with clearing read
        wr(8'h02, 8'h07, "R2");
        events(3'b001, 3);
        cyc(3'b001, 1, 0, 8'h04, 8'h00, "R6");
        rd(8'h05, "R6");
        // R7: snapshot of upper bytes, held while counter moves
        events(3'b001, 300);
        rd(8'h05, "R7"); rd(8'h00, "R7"); rd(8'h01, "R7");
        events(3'b001, 20);
        rd(8'h00, "R7");
        rd(8'h07, "R7"); rd(8'h00, "R7");
        // R3 / R9: saturate the transmitted-cell counter
        events(3'b001, 4000);
        rd(8'h05, "R3"); rd(8'h00, "R3");
        rd(8'h3A, "R9");
        wr(8'h3A, 8'h02, "R9");
        rd(8'h3A, "R9");
        rd(8'h04, "R5"); wr(8'h3A, 8'h0E, "R9"); rd(8'h3A, "R9");
        // R8: threshold crossing, set wins over clear, clear after condition drops
        wr(8'h0A, 8'h03, "R8");
        rd(8'h08, "R8"); wr(8'h3A, 8'h01, "R8"); rd(8'h3A, "R8");
        events(3'b100, 3);
        rd(8'h3A, "R8");
        wr(8'h3A, 8'h01, "R8"); rd(8'h3A, "R8");
        rd(8'h08, "R8"); wr(8'h3A, 8'h01, "R8"); rd(8'h3A, "R8");
        // R10: masking of the interrupt paths
        events(3'b100, 4);
        wr(8'h3B, 8'h01, "R10"); rd(8'h38, "R10");
        wr(8'h3B, 8'h00, "R10"); wr(8'h39, 8'h01, "R10"); rd(8'h38, "R10");
        wr(8'h39, 8'h00, "R10");
        // R11: writes to counters and snapshots ignored, unmapped reads zero
        wr(8'h05, 8'hA5, "R11"); wr(8'h00, 8'h5A, "R11");
        rd(8'h05, "R11"); rd(8'h00, "R11"); rd(8'h20, "R11"); rd(8'hFF, "R11");

        // Seeded random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [2:0] ev;
            bit r, w;
            logic [7:0] a, d;
            ev = 3'($urandom);
            r  = ($urandom % 4) == 0;
            w  = !r && ($urandom % 16) == 0;
            a  = addrs[$urandom % 15];
            d  = 8'($urandom);
            if (w && a == 8'h02) d = ($urandom % 4 == 0) ? d : 8'h07;
            if (w && a == 8'h3B) d = d & 8'h03;
            cyc(ev, r, w, a, d, tag_of(a));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule